// File: doc/BRIEF.md
# Dual-Radix Compound Adder

This combinational adder takes two operands of DIGITS four-bit digits each. It treats them either as binary-coded decimal numbers or as plain binary nibbles, depending on a radix select input. It forms three results in one pass:

- the sum,
- the sum plus one,
- the digit-wise complement of the sum.

It also reports the carry out of the top digit. For an effective subtraction that carry is the end-around carry, and it picks the absolute difference of the two operands.

Every digit computes a five-bit partial sum, which yields a generate and a propagate bit. Two carry chains run over these bits, one with carry-in 0 and one with carry-in 1. Each output digit is then taken from the partial sum plus the carry that reaches it.

In decimal mode, operand B is pre-biased by six. A digit that ends without a carry is then reduced by six again, which keeps every digit in the range 0 to 9. In binary mode neither bias is applied. For subtraction, operand B is replaced by its digit-wise complement before it enters the adder. A fourth output gives the magnitude result that a normalizer would consume.

Top module: `dual_radix_cadd`

## Requirements
- R1: In binary mode (dec_mode=0) with eff_sub=0, {carry_out, sum0} equals op_a + op_b as unsigned binary integers of 4*DIGITS bits.
- R2: In decimal mode (dec_mode=1) with eff_sub=0 and BCD inputs (every digit 0..9, digit 0 in bits [3:0]), sum0 is the BCD encoding of (A + B) mod 10^DIGITS, and carry_out is 1 exactly when A + B >= 10^DIGITS.
- R3: sum1 equals sum0 + 1 in the selected radix, modulo the radix raised to DIGITS. An all-nines (decimal) or all-ones (binary) sum0 wraps sum1 to zero.
- R4: Each digit of sum_inv is the complement of the same digit of sum0: 9 minus the digit in decimal mode, 15 minus the digit in binary mode.
- R5: With eff_sub=1, the adder uses the digit-wise complement of op_b in place of op_b (nines' complement in decimal, ones' complement in binary). carry_out is therefore 1 exactly when A > B.
- R6: sel_res equals sum0 when eff_sub=0. When eff_sub=1 it equals A - B if carry_out is 1 (taken from sum1), and otherwise B - A (taken from sum_inv). It is zero when A equals B.
- R7: In decimal mode with BCD inputs, every digit of sum0, sum1, sum_inv and sel_res lies in 0..9.
- R8: In binary mode, digit values 10 to 15 are ordinary nibble values and no digit receives a six correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4*DIGITS | Operand A, digit 0 in bits [3:0] |
| op_b | input | 4*DIGITS | Operand B, same layout |
| dec_mode | input | 1 | 1 selects decimal digits, 0 selects binary nibbles |
| eff_sub | input | 1 | 1 for effective subtraction |
| sum0 | output | 4*DIGITS | A + B' |
| sum1 | output | 4*DIGITS | A + B' + 1 |
| sum_inv | output | 4*DIGITS | Digit-wise complement of sum0 |
| sel_res | output | 4*DIGITS | Normalizer result: the sum, or the absolute difference |
| carry_out | output | 1 | Carry out of the top digit (the end-around carry when subtracting) |

## Verification
The decimal checks take for granted that both operands hold valid BCD digits. A digit above nine in decimal mode has no defined result, so the digit-range property is tested only when every input digit is 0..9. The stimulus keeps to this by building decimal operands from integers 0..99, encoded digit by digit. The binary properties hold for every input value, and the binary sweep covers every nibble pattern, including 10 to 15.

// File: rtl/dual_radix_cadd.sv
module dual_radix_cadd #(
  parameter int unsigned DIGITS = 37
) (
  input  logic [4*DIGITS-1:0] op_a,
  input  logic [4*DIGITS-1:0] op_b,
  input  logic                dec_mode,
  input  logic                eff_sub,
  output logic [4*DIGITS-1:0] sum0,
  output logic [4*DIGITS-1:0] sum1,
  output logic [4*DIGITS-1:0] sum_inv,
  output logic [4*DIGITS-1:0] sel_res,
  output logic                carry_out
);

  logic [DIGITS:0] cy0;
  logic [DIGITS:0] cy1;

  assign cy0[0] = 1'b0;
  assign cy1[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] ad, bd, bx, d0, d1;
    logic [4:0] t, u0, u1;
    logic       gen, prop;

    assign ad = op_a[4*i +: 4];
    assign bd = op_b[4*i +: 4];
    assign bx = eff_sub ? ~bd : (dec_mode ? bd + 4'd6 : bd);
    assign t  = {1'b0, ad} + {1'b0, bx};

    assign gen  = t[4];
    assign prop = (t[3:0] == 4'hF);

    assign cy0[i+1] = gen | (prop & cy0[i]);
    assign cy1[i+1] = gen | (prop & cy1[i]);

    assign u0 = t + {4'd0, cy0[i]};
    assign u1 = t + {4'd0, cy1[i]};

    assign d0 = (dec_mode & ~cy0[i+1]) ? u0[3:0] + 4'd10 : u0[3:0];
    assign d1 = (dec_mode & ~cy1[i+1]) ? u1[3:0] + 4'd10 : u1[3:0];

    assign sum0[4*i +: 4]    = d0;
    assign sum1[4*i +: 4]    = d1;
    assign sum_inv[4*i +: 4] = dec_mode ? 4'd9 - d0 : ~d0;
  end

  assign carry_out = cy0[DIGITS];
  assign sel_res   = !eff_sub ? sum0 : (carry_out ? sum1 : sum_inv);

endmodule

// File: rtl/dual_radix_cadd_chk.sv
module dual_radix_cadd_chk #(
  parameter int unsigned DIGITS = 37
) (
  input logic [4*DIGITS-1:0] op_a,
  input logic [4*DIGITS-1:0] op_b,
  input logic                dec_mode,
  input logic                eff_sub,
  input logic [4*DIGITS-1:0] sum0,
  input logic [4*DIGITS-1:0] sum1,
  input logic [4*DIGITS-1:0] sum_inv,
  input logic [4*DIGITS-1:0] sel_res,
  input logic                carry_out
);

  localparam int unsigned W = 4*DIGITS;

  logic in_bcd;
  logic out_bcd;

  always_comb begin
    in_bcd  = 1'b1;
    out_bcd = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (op_a[4*i +: 4] > 4'd9 || op_b[4*i +: 4] > 4'd9) in_bcd = 1'b0;
      if (sum0[4*i +: 4] > 4'd9 || sum1[4*i +: 4] > 4'd9 ||
          sum_inv[4*i +: 4] > 4'd9 || sel_res[4*i +: 4] > 4'd9) out_bcd = 1'b0;
    end
  end

  always_comb begin
    // R1
    if (!dec_mode && !eff_sub)
      bin_add_chk: assert ({carry_out, sum0} == {1'b0, op_a} + {1'b0, op_b});
    // R3
    if (!dec_mode)
      bin_inc_chk: assert (sum1 == sum0 + {{(W-1){1'b0}}, 1'b1});
    // R5
    if (!dec_mode && eff_sub)
      bin_eac_chk: assert (carry_out == (op_a > op_b));
    // R6
    if (!dec_mode && eff_sub)
      bin_absdiff_chk: assert (sel_res == ((op_a > op_b) ? op_a - op_b : op_b - op_a));
    // R7
    if (dec_mode && in_bcd)
      digit_range_chk: assert (out_bcd);
  end

endmodule

bind dual_radix_cadd dual_radix_cadd_chk #(.DIGITS(DIGITS)) u_chk (
  .op_a(op_a), .op_b(op_b), .dec_mode(dec_mode), .eff_sub(eff_sub),
  .sum0(sum0), .sum1(sum1), .sum_inv(sum_inv), .sel_res(sel_res),
  .carry_out(carry_out)
);

// File: tb/dual_radix_cadd_test.sv
`timescale 1ns/1ps
module dual_radix_cadd_test;

  localparam int ND = 2;
  localparam int W  = 4*ND;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2*W+1:0] stim = '0;
  logic [W-1:0] s0, s1, si, sr;
  logic         co;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dual_radix_cadd #(.DIGITS(ND)) uut (
    .op_a(stim[W-1:0]), .op_b(stim[2*W-1:W]),
    .dec_mode(stim[2*W]), .eff_sub(stim[2*W+1]),
    .sum0(s0), .sum1(s1), .sum_inv(si), .sel_res(sr), .carry_out(co)
  );

  function automatic logic [W-1:0] enc(int v, bit dec);
    logic [W-1:0] r;
    int x;
    r = '0;
    x = v;
    for (int k = 0; k < ND; k++) begin
      if (dec) begin
        r[4*k +: 4] = 4'(x % 10);
        x = x / 10;
      end else begin
        r[4*k +: 4] = 4'(x % 16);
        x = x / 16;
      end
    end
    return r;
  endfunction

  task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails < 20) $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(int a, int b, bit dec, bit sub);
    int rad, bv, s, h0, h1, hc, hn;
    bit ec, ok;
    string t0;
    rad = dec ? 100 : 256;
    bv  = sub ? rad - 1 - b : b;
    s   = a + bv;
    ec  = (s >= rad);
    h0  = s % rad;
    h1  = (s + 1) % rad;
    hc  = rad - 1 - h0;
    hn  = !sub ? h0 : (ec ? h1 : hc);
    @(negedge clk);
    stim = {sub, dec, enc(b, dec), enc(a, dec)};
    #1;
    // R1/R8 binary add, R2 decimal add, R5 subtraction
    t0 = sub ? "R5" : (dec ? "R2" : "R1/R8");
    cmp(t0, s0, enc(h0, dec));
    cmp(t0, {{(W-1){1'b0}}, co}, {{(W-1){1'b0}}, ec});
    cmp("R3", s1, enc(h1, dec));
    cmp("R4", si, enc(hc, dec));
    cmp("R6", sr, enc(hn, dec));
    if (dec) begin
      ok = 1'b1;
      for (int k = 0; k < ND; k++)
        if (s0[4*k +: 4] > 4'd9 || s1[4*k +: 4] > 4'd9 ||
            si[4*k +: 4] > 4'd9 || sr[4*k +: 4] > 4'd9) ok = 1'b0;
      // R7
      cmp("R7", {{(W-1){1'b0}}, ok}, {{(W-1){1'b0}}, 1'b1});
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // idle vector first: zero operands, decimal add
    run_vec(0, 0, 1'b1, 1'b0);
    // boundaries: wrap of sum1, equal operands, top carry
    run_vec(99, 0, 1'b1, 1'b0);
    run_vec(99, 99, 1'b1, 1'b0);
    run_vec(37, 37, 1'b1, 1'b1);
    run_vec(255, 0, 1'b0, 1'b0);
    run_vec(200, 200, 1'b0, 1'b1);
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 100; a++)
        for (int b = 0; b < 100; b++)
          run_vec(a, b, 1'b1, op[0]);
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          run_vec(a, b, 1'b0, op[0]);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule